// File: doc/BRIEF.md
# Frame Capture Exposure Sequencer

This block schedules the capture of a programmed number of frames on an image sensor that has a masked storage section. For each frame it orders four steps: emptying the image array, integrating light for a programmed number of clock cycles, moving the charge into storage, and telling a separate readout sequencer to start. The readout sequencer answers with a one-cycle done pulse when the stored frame has been read.

Three scheduling modes are offered. In the sequential mode each frame is read out completely before the next one is cleared. In the overlapped mode the readout of one frame runs while the next frame integrates, and a readout-only tail follows the last move. In the triggered mode one rising edge on an external trigger pin starts a run that is sequential in its ordering. The block reports how many frames have been moved to storage and how many clock cycles the run has taken, so that a run's total time can be checked against the expected schedule.

Top module: `expo_seq_ctrl`

## Requirements
- R1: After reset, clearStb, integrate, transferStb, readStartStb and busy are 0, and frameCount and cycleCount are 0.
- R2: modeSel encodes the schedule as 0 sequential, 1 overlapped, 2 triggered and 3 sequential. In modes 0, 1 and 3 a run starts on a clock edge where seqStart is 1, and trigIn is ignored. In mode 2 only a trigIn rising edge starts a run, and seqStart is ignored. Mode, exposure length E and frame count N are captured when the run starts.
- R3: In sequential order each frame is clearStb for 1 cycle, then integrate for exactly E cycles, then transferStb for 1 cycle, then readStartStb in the next cycle. The next frame's clear comes in the cycle after the readDone pulse.
- R4: A sequential or triggered run of N frames, with readDone arriving R cycles after readStartStb, takes N*(E+R+3) busy cycles.
- R5: In overlapped mode clearStb is issued once per run. The next frame's integrate starts in the cycle after each transfer that is not the last, so N-1 of the N readStartStb pulses occur while integrate is 1.
- R6: In overlapped mode every integrate run lasts exactly E cycles. When E > R the run takes N*(E+1)+R+2 busy cycles, and this includes a readout-only tail after the last transfer.
- R7: In overlapped mode, an exposure that ends before the previous frame's readDone holds integrate low and delays the transfer until the cycle after readDone. The general total is 1+(E+1)+(N-1)*(max(E,R+1)+1)+(R+1).
- R8: trigIn passes through a two-stage synchronizer and an edge detector. When trigIn rises before a clock edge, clearStb appears in the third cycle after that edge. A trigIn that stays high starts only one run.
- R9: seqStart and trigIn pulses that arrive while busy is 1 have no effect on the run's frameCount or cycleCount.
- R10: A start request with E = 0 or N = 0 is ignored, and busy stays 0.
- R11: frameCount is cleared at the start of a run and increments by one on each transfer, ending at N. cycleCount is cleared at the start and increments on every busy cycle. Both hold their values once the run ends.
- R12: Every transferStb is followed in the next cycle by readStartStb, and readStartStb occurs at no other time. clearStb, integrate and transferStb are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Schedule select (0 sequential, 1 overlapped, 2 triggered, 3 sequential) |
| expoCycles | input | EXP_W | Exposure length E in clock cycles |
| frameTotal | input | FRM_W | Frame count N |
| seqStart | input | 1 | Start request for modes 0, 1 and 3 |
| trigIn | input | 1 | Asynchronous external trigger for mode 2 |
| readDone | input | 1 | One-cycle pulse from the readout sequencer |
| clearStb | output | 1 | Empty the image array |
| integrate | output | 1 | High while the frame is exposing |
| transferStb | output | 1 | Move the image charge to storage |
| readStartStb | output | 1 | Start reading the stored frame |
| busy | output | 1 | A run is in progress |
| frameCount | output | FRM_W | Frames moved to storage in the current or last run |
| cycleCount | output | CYC_W | Busy cycles in the current or last run |

## Verification
The hardest case to reach is an overlapped run in which an exposure ends while the previous readout is still in progress, because that case alone exercises the hold state and the late transfer. The bench reaches it through a behavioural readout model whose read time is set per run. It runs overlapped sequences with R well above E, and also with E equal to R and E equal to R+1, which lie on both sides of the point where the hold first occurs. It compares each total against the schedule formula and checks that every exposure stays at exactly E cycles.

// File: rtl/expo_seq_pkg.sv
`timescale 1ns/1ps
package expo_seq_pkg;

  typedef enum logic [1:0] {
    MODE_SEQ     = 2'd0,
    MODE_OVL     = 2'd1,
    MODE_TRIG    = 2'd2,
    MODE_SEQ_ALT = 2'd3
  } capMode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_CLEAR  = 3'd1,
    ST_EXPOSE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_MOVE   = 3'd4,
    ST_DRAIN  = 3'd5
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic expose;
    logic move;
    logic busy;
  } ctlStrobe_t;

endpackage

// File: rtl/expo_trig_sync.sv
`timescale 1ns/1ps
module expo_trig_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigIn,
  output logic trigRise
);

  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] shReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shReg <= '0;
    else        shReg <= {shReg[SH_W-2:0], trigIn};
  end

  assign trigRise = shReg[SYNC_STAGES-1] & ~shReg[SYNC_STAGES];

endmodule

// File: rtl/expo_seq_fsm.sv
`timescale 1ns/1ps
module expo_seq_fsm
  import expo_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] modeSel,
  input  logic       seqStart,
  input  logic       trigRise,
  input  logic       cfgOk,
  input  logic       expLast,
  input  logic       readFree,
  input  logic       lastFrame,
  input  logic       allFrames,
  input  logic       readDone,
  output ctlStrobe_t ctl
);

  seqState_e state, nextState;
  logic      ovlRun;
  logic      goCmd;

  assign goCmd = (modeSel == MODE_TRIG) ? trigRise : seqStart;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:   if (goCmd && cfgOk) nextState = ST_CLEAR;
      ST_CLEAR:  nextState = ST_EXPOSE;
      ST_EXPOSE: if (expLast) nextState = readFree ? ST_MOVE : ST_HOLD;
      ST_HOLD:   if (readFree) nextState = ST_MOVE;
      ST_MOVE:   nextState = (ovlRun && !lastFrame) ? ST_EXPOSE : ST_DRAIN;
      ST_DRAIN:  if (readDone) nextState = allFrames ? ST_IDLE : ST_CLEAR;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ovlRun <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_IDLE && goCmd && cfgOk)
        ovlRun <= (modeSel == MODE_OVL);
    end
  end

  always_comb begin
    ctl.load   = (state == ST_IDLE) && goCmd && cfgOk;
    ctl.clear  = (state == ST_CLEAR);
    ctl.expose = (state == ST_EXPOSE);
    ctl.move   = (state == ST_MOVE);
    ctl.busy   = (state != ST_IDLE);
  end

endmodule

// File: rtl/expo_seq_dp.sv
`timescale 1ns/1ps
module expo_seq_dp
  import expo_seq_pkg::*;
#(
  parameter int EXP_W = 16,
  parameter int FRM_W = 8,
  parameter int CYC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctlStrobe_t       ctl,
  input  logic [EXP_W-1:0] expoCycles,
  input  logic [FRM_W-1:0] frameTotal,
  input  logic             readDone,
  output logic             expLast,
  output logic             readFree,
  output logic             lastFrame,
  output logic             allFrames,
  output logic             readStartStb,
  output logic [FRM_W-1:0] frameCount,
  output logic [CYC_W-1:0] cycleCount
);

  logic [EXP_W-1:0] expoReg;
  logic [EXP_W-1:0] expCnt;
  logic [FRM_W-1:0] framesReg;
  logic             pending;

  assign expLast   = ctl.expose && (expCnt == expoReg - EXP_W'(1));
  assign readFree  = !pending || readDone;
  assign lastFrame = (frameCount == framesReg - FRM_W'(1));
  assign allFrames = (frameCount == framesReg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      expoReg      <= '0;
      framesReg    <= '0;
      expCnt       <= '0;
      frameCount   <= '0;
      cycleCount   <= '0;
      pending      <= 1'b0;
      readStartStb <= 1'b0;
    end else begin
      if (ctl.load) begin
        expoReg    <= expoCycles;
        framesReg  <= frameTotal;
        frameCount <= '0;
        cycleCount <= '0;
      end else begin
        if (ctl.busy) cycleCount <= cycleCount + CYC_W'(1);
        if (ctl.move) frameCount <= frameCount + FRM_W'(1);
      end
      expCnt       <= (ctl.expose && !expLast) ? expCnt + EXP_W'(1) : '0;
      readStartStb <= ctl.move;
      if (ctl.move)      pending <= 1'b1;
      else if (readDone) pending <= 1'b0;
    end
  end

endmodule

// File: rtl/expo_seq_ctrl.sv
`timescale 1ns/1ps
module expo_seq_ctrl
  import expo_seq_pkg::*;
#(
  parameter int EXP_W       = 16,
  parameter int FRM_W       = 8,
  parameter int CYC_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       modeSel,
  input  logic [EXP_W-1:0] expoCycles,
  input  logic [FRM_W-1:0] frameTotal,
  input  logic             seqStart,
  input  logic             trigIn,
  input  logic             readDone,
  output logic             clearStb,
  output logic             integrate,
  output logic             transferStb,
  output logic             readStartStb,
  output logic             busy,
  output logic [FRM_W-1:0] frameCount,
  output logic [CYC_W-1:0] cycleCount
);

  ctlStrobe_t ctl;
  logic trigRise, cfgOk, expLast, readFree, lastFrame, allFrames;

  assign cfgOk = (|expoCycles) && (|frameTotal);

  expo_trig_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .trigIn(trigIn), .trigRise(trigRise)
  );

  expo_seq_fsm fsm_i (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .seqStart(seqStart),
    .trigRise(trigRise), .cfgOk(cfgOk), .expLast(expLast),
    .readFree(readFree), .lastFrame(lastFrame), .allFrames(allFrames),
    .readDone(readDone), .ctl(ctl)
  );

  expo_seq_dp #(.EXP_W(EXP_W), .FRM_W(FRM_W), .CYC_W(CYC_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .expoCycles(expoCycles),
    .frameTotal(frameTotal), .readDone(readDone), .expLast(expLast),
    .readFree(readFree), .lastFrame(lastFrame), .allFrames(allFrames),
    .readStartStb(readStartStb), .frameCount(frameCount),
    .cycleCount(cycleCount)
  );

  assign clearStb    = ctl.clear;
  assign integrate   = ctl.expose;
  assign transferStb = ctl.move;
  assign busy        = ctl.busy;

endmodule

// File: rtl/expo_seq_chk.sv
`timescale 1ns/1ps
module expo_seq_chk #(
  parameter int FRM_W = 8,
  parameter int CYC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clearStb,
  input logic             integrate,
  input logic             transferStb,
  input logic             readStartStb,
  input logic             busy,
  input logic [FRM_W-1:0] frameCount,
  input logic [CYC_W-1:0] cycleCount
);

  // R12
  move_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    transferStb |=> readStartStb);

  // R12
  read_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    readStartStb |-> $past(transferStb));

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({clearStb, integrate, transferStb}));

  // R3
  clear_then_expose_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clearStb |=> integrate);

  // R11
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !transferStb) |=> (frameCount == $past(frameCount)));

  // R11
  cycle_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cycleCount == $past(cycleCount) + CYC_W'(1)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!clearStb && !integrate && !transferStb));

endmodule

bind expo_seq_ctrl expo_seq_chk #(.FRM_W(FRM_W), .CYC_W(CYC_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .clearStb(clearStb), .integrate(integrate),
  .transferStb(transferStb), .readStartStb(readStartStb), .busy(busy),
  .frameCount(frameCount), .cycleCount(cycleCount)
);

// File: tb/expo_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module expo_seq_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  modeSel = 2'd0;
  logic [15:0] expoCycles = 16'd0;
  logic [7:0]  frameTotal = 8'd0;
  logic        seqStart = 1'b0;
  logic        trigIn = 1'b0;
  logic        readDone = 1'b0;
  logic        clearStb, integrate, transferStb, readStartStb, busy;
  logic [7:0]  frameCount;
  logic [31:0] cycleCount;

  int checks = 0;
  int errors = 0;
  int readTime = 1;
  int rdLeft = 0;
  int nClear, nMove, nRead, nReadInt, runLen, runMin, runMax;

  always #2 clk = ~clk;

  expo_seq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .modeSel(modeSel), .expoCycles(expoCycles),
    .frameTotal(frameTotal), .seqStart(seqStart), .trigIn(trigIn),
    .readDone(readDone), .clearStb(clearStb), .integrate(integrate),
    .transferStb(transferStb), .readStartStb(readStartStb), .busy(busy),
    .frameCount(frameCount), .cycleCount(cycleCount)
  );

  // readout sequencer model: done pulse readTime cycles after start
  always @(negedge clk) begin
    readDone = 1'b0;
    if (readStartStb) rdLeft = readTime;
    else if (rdLeft > 0) begin
      rdLeft = rdLeft - 1;
      if (rdLeft == 0) readDone = 1'b1;
    end
  end

  // strobe monitor
  always @(negedge clk) begin
    if (clearStb) nClear++;
    if (transferStb) nMove++;
    if (readStartStb) begin
      nRead++;
      if (integrate) nReadInt++;
    end
    if (integrate) runLen++;
    else if (runLen != 0) begin
      if (runLen < runMin) runMin = runLen;
      if (runLen > runMax) runMax = runLen;
      runLen = 0;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    nClear = 0; nMove = 0; nRead = 0; nReadInt = 0;
    runLen = 0; runMin = 1 << 30; runMax = 0;
  endtask

  function automatic int expTotal(input int mode, input int e, input int n, input int r);
    int slot;
    if (mode == 1) begin
      slot = (e > r + 1) ? e : r + 1;
      return 1 + (e + 1) + (n - 1) * (slot + 1) + (r + 1);
    end
    return n * (e + r + 3);
  endfunction

  task automatic waitIdle(input string tag);
    int k;
    k = 0;
    while (!busy && k < 20) begin @(negedge clk); k++; end
    k = 0;
    while (busy && k < 20000) begin @(negedge clk); k++; end
    if (busy || k == 0) chk(1'b0, {tag, " run did not complete"}, k, 0);
  endtask

  task automatic setCfg(input int mode, input int e, input int n, input int r);
    @(negedge clk);
    modeSel = 2'(mode); expoCycles = 16'(e); frameTotal = 8'(n); readTime = r;
  endtask

  task automatic pulseStart();
    @(negedge clk); seqStart = 1'b1;
    @(negedge clk); seqStart = 1'b0;
  endtask

  task automatic pulseTrig();
    @(negedge clk); trigIn = 1'b1;
    repeat (4) @(negedge clk);
    trigIn = 1'b0;
  endtask

  task automatic runSeq(input int mode, input int e, input int n, input int r, input string tag);
    int expClr, expRi;
    setCfg(mode, e, n, r);
    clearMon();
    if (mode == 2) pulseTrig(); else pulseStart();
    waitIdle(tag);
    @(negedge clk);
    expClr = (mode == 1) ? 1 : n;
    expRi  = (mode == 1) ? n - 1 : 0;
    chk(cycleCount == 32'(expTotal(mode, e, n, r)), {tag, " total cycles"}, cycleCount, expTotal(mode, e, n, r));
    chk(frameCount == 8'(n), {tag, " R11 frameCount"}, frameCount, n);
    chk(nMove == n && nRead == n, {tag, " R12 transfers/readStarts"}, nMove * 1000 + nRead, n * 1000 + n);
    chk(runMin == e && runMax == e, {tag, " R6 exposure length"}, runMin * 1000 + runMax, e * 1000 + e);
    chk(nClear == expClr, {tag, " R5 clear count"}, nClear, expClr);
    chk(nReadInt == expRi, {tag, " R5 readout during exposure"}, nReadInt, expRi);
  endtask

  task automatic testReset();
    chk(!clearStb && !integrate && !transferStb && !readStartStb && !busy,
        "R1 strobes after reset", {clearStb, integrate, transferStb, readStartStb, busy}, 0);
    chk(frameCount == 0 && cycleCount == 0, "R1 counters after reset", cycleCount, 0);
  endtask

  task automatic testIgnoreBusy();
    setCfg(0, 6, 2, 4);
    pulseStart();
    repeat (5) @(negedge clk);
    seqStart = 1'b1; trigIn = 1'b1;
    @(negedge clk);
    seqStart = 1'b0;
    repeat (3) @(negedge clk);
    trigIn = 1'b0;
    waitIdle("R9");
    @(negedge clk);
    chk(cycleCount == 32'(expTotal(0, 6, 2, 4)), "R9 total with busy starts", cycleCount, expTotal(0, 6, 2, 4));
    chk(frameCount == 8'd2, "R9 frameCount with busy starts", frameCount, 2);
  endtask

  task automatic testIdleIgnore();
    bit seen;
    setCfg(0, 3, 1, 2);
    pulseTrig();
    seen = 0;
    repeat (6) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R2 trigIn ignored in mode 0", seen, 0);
    setCfg(2, 3, 1, 2);
    pulseStart();
    seen = 0;
    repeat (6) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R2 seqStart ignored in mode 2", seen, 0);
    setCfg(0, 0, 2, 2);
    pulseStart();
    seen = 0;
    repeat (6) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R10 E=0 ignored", seen, 0);
    setCfg(1, 3, 0, 2);
    pulseStart();
    seen = 0;
    repeat (6) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R10 N=0 ignored", seen, 0);
  endtask

  task automatic testTrigLatency();
    int k;
    bit seen;
    setCfg(2, 3, 1, 2);
    @(negedge clk); trigIn = 1'b1;
    k = 0;
    do begin @(negedge clk); k++; end while (!clearStb && k < 10);
    chk(k == 3, "R8 trigger to clear latency", k, 3);
    waitIdle("R8");
    @(negedge clk);
    chk(cycleCount == 32'(expTotal(2, 3, 1, 2)), "R8 triggered total", cycleCount, expTotal(2, 3, 1, 2));
    seen = 0;
    repeat (8) begin @(negedge clk); if (busy) seen = 1; end
    chk(!seen, "R8 held trigger starts one run", seen, 0);
    trigIn = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    testReset();
    runSeq(0, 10, 3, 50, "R3 R4 sequential");
    runSeq(1, 75, 3, 50, "R6 overlapped long exposure");
    runSeq(1, 5, 4, 20, "R7 overlapped slow readout");
    runSeq(1, 8, 2, 7, "R7 overlapped E=R+1");
    runSeq(1, 6, 2, 6, "R7 overlapped E=R");
    runSeq(1, 3, 1, 2, "R6 overlapped single frame");
    runSeq(2, 4, 2, 3, "R2 triggered");
    runSeq(3, 2, 2, 1, "R2 mode 3 sequential");
    testIgnoreBusy();
    testIdleIgnore();
    testTrigLatency();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule